// File: doc/BRIEF.md
# Receive Packet Admission Controller

This block sits between a MAC receive path and a circular receive buffer. It decides, byte by byte, whether an incoming frame can still be stored. It produces the buffer write strobe and the write address. It also keeps an 8-bit count of complete packets that are waiting for firmware. A frame is refused and discarded for either of two reasons: a byte arrives while the ring has no free location, or a frame starts while the pending count already stands at 255. When a frame is discarded, the write address returns to where that frame began, so no partial frame is left behind.

Firmware talks to the block through a small byte-wide register port. Through it, firmware moves the ring's 16-bit read pointer in two steps, low byte then high byte. It also decrements the pending count and clears a sticky receive-error flag. The flag is set by every discard. It drives an interrupt only when both its own enable and the global Ethernet interrupt enable are high; otherwise firmware can poll it.

Top module: `rx_admit_ctrl`

## Requirements
- R1: After reset, `pkt_count` is 0, `rx_err` is 0, `wr_addr` is 0, `rd_ptr` is 0 and `irq` is 0.
- R2: While a frame is being received and the ring has at least one free location, each `byte_vld` asserts `wr_en` in that same cycle at the current `wr_addr`. `wr_addr` then advances by one, modulo 2**ADDR_W.
- R3: Free space is (read − write − 1) modulo 2**ADDR_W, where read is the low ADDR_W bits of `rd_ptr`, so one location always stays empty. A byte that arrives with zero free space is not written (`wr_en` low) and aborts the frame.
- R4: On an abort, `wr_addr` returns to the address it held at the frame's `frm_start`. All later bytes of that frame are ignored (no `wr_en`, no address change) until its `frm_end`.
- R5: A `frm_start` seen while `pkt_count` is 255 aborts that frame. None of its bytes is stored, and its `frm_end` does not change the count.
- R6: Every abort sets `rx_err` on the next clock edge.
- R7: `rx_err` stays 1 until a register write with `reg_sel`=2'b11 (data ignored) clears it. If an abort and a clear write fall in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when `rx_err`, `err_ie` and `eth_ie` are all 1.
- R9: A `frm_end` that closes a frame with no abort increments `pkt_count` by one on the next edge.
- R10: A register write with `reg_sel`=2'b10 (data ignored) decrements `pkt_count`. It has no effect when the count is 0. If it coincides with an increment, the count does not change.
- R11: A write with `reg_sel`=2'b00 stores `reg_wdata` as a pending low byte and leaves `rd_ptr` unchanged. A write with `reg_sel`=2'b01 sets `rd_ptr` to {`reg_wdata`, pending low byte} in one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | First-cycle strobe of an incoming frame |
| byte_vld | input | 1 | One received byte is offered this cycle |
| frm_end | input | 1 | Strobe after the last byte of a frame |
| wr_en | output | 1 | Store the offered byte in the ring |
| wr_addr | output | ADDR_W | Ring address for the next stored byte |
| reg_we | input | 1 | Firmware register write strobe |
| reg_sel | input | 2 | Register select: 00 read-pointer low, 01 read-pointer high, 10 count decrement, 11 error clear |
| reg_wdata | input | 8 | Firmware write data |
| rd_ptr | output | 16 | Committed read pointer |
| pkt_count | output | 8 | Pending complete packets |
| err_ie | input | 1 | Receive-error interrupt enable |
| eth_ie | input | 1 | Global Ethernet interrupt enable |
| rx_err | output | 1 | Sticky receive-error flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a frame completes while firmware writes a count decrement. In the second, a byte arrives into a full ring while firmware writes an error clear. The bench drives each pair into a single clock edge. It judges the first by an unchanged `pkt_count` and the second by `rx_err` reading 1 afterwards, with the frame discarded. The ring is also filled across the address wrap, and the count is pushed to 255 with empty frames, so that the saturation drop can be observed at the ports.

// File: rtl/rx_admit_pkg.sv
package rx_admit_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_TAKE = 2'd1,
        RX_DROP = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        SEL_RDLO  = 2'b00,
        SEL_RDHI  = 2'b01,
        SEL_PKDEC = 2'b10,
        SEL_ECLR  = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic lo_we;
        logic hi_we;
        logic dec;
        logic clr;
    } reg_cmd_t;

    function automatic reg_cmd_t decode_reg(input logic we, input logic [1:0] sel);
        reg_cmd_t c;
        c.lo_we = we && (sel == SEL_RDLO);
        c.hi_we = we && (sel == SEL_RDHI);
        c.dec   = we && (sel == SEL_PKDEC);
        c.clr   = we && (sel == SEL_ECLR);
        return c;
    endfunction

    function automatic logic [15:0] ring_free(input logic [15:0] wr,
                                              input logic [15:0] rd,
                                              input logic [15:0] mask);
        return (rd - wr - 16'd1) & mask;
    endfunction

endpackage

// File: rtl/rx_admit_rdptr.sv
module rx_admit_rdptr (
    input  logic        clk,
    input  logic        rst,
    input  logic        lo_we,
    input  logic        hi_we,
    input  logic [7:0]  wdata,
    output logic [15:0] rd_ptr
);
    logic [7:0] lo_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold <= '0;
            rd_ptr  <= '0;
        end else begin
            if (lo_we) lo_hold <= wdata;
            if (hi_we) rd_ptr  <= {wdata, lo_hold};
        end
    end

    // R11: a low-byte write alone never moves the committed pointer
    a_r11_lo_no_commit: assert property (@(posedge clk) disable iff (rst)
        (lo_we && !hi_we) |=> $stable(rd_ptr));
endmodule

// File: rtl/rx_admit_pktcnt.sv
module rx_admit_pktcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec_req,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic dec_ok;
    assign dec_ok = dec_req && (cnt != '0);
    assign full   = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && !dec_ok) begin
            cnt <= cnt + 1'b1;
        end else if (dec_ok && !inc) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R10: coincident increment and decrement keep the count
    a_r10_inc_dec_hold: assert property (@(posedge clk) disable iff (rst)
        (inc && dec_req && cnt != '0) |=> $stable(cnt));
    // R10: decrement at zero has no effect
    a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !inc) |=> (cnt == '0));
    // R9: a successful frame adds one
    a_r9_count_up: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec_req) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rx_admit_wrptr.sv
module rx_admit_wrptr
    import rx_admit_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mark,
    input  logic              advance,
    input  logic              rollback,
    input  logic [15:0]       rd_ptr,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              ring_full
);
    localparam logic [15:0] RING_MASK = 16'((32'd1 << ADDR_W) - 32'd1);

    logic [ADDR_W-1:0] base_ptr;
    logic [15:0]       free_cnt;

    assign free_cnt  = ring_free(16'(wr_ptr), rd_ptr, RING_MASK);
    assign ring_full = (free_cnt == 16'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            base_ptr <= '0;
        end else begin
            if (mark)          base_ptr <= wr_ptr;
            if (rollback)      wr_ptr   <= base_ptr;
            else if (advance)  wr_ptr   <= wr_ptr + 1'b1;
        end
    end

    // R4: an abort returns the write address to the frame start
    a_r4_rollback: assert property (@(posedge clk) disable iff (rst)
        (rollback && !mark) |=> (wr_ptr == $past(base_ptr)));
    // R3: a byte is never stored into the last free location
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
        advance |-> !ring_full);
endmodule

// File: rtl/rx_admit_ctrl.sv
module rx_admit_ctrl
    import rx_admit_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              byte_vld,
    input  logic              frm_end,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [15:0]       rd_ptr,
    output logic [CNT_W-1:0]  pkt_count,
    input  logic              err_ie,
    input  logic              eth_ie,
    output logic              rx_err,
    output logic              irq
);
    rx_state_e st;
    reg_cmd_t  cmd;
    logic      cnt_full;
    logic      ring_full;
    logic      start_ok;
    logic      start_drop;
    logic      byte_drop;
    logic      abort;
    logic      commit;

    assign cmd        = decode_reg(reg_we, reg_sel);
    assign start_ok   = (st == RX_IDLE) && frm_start && !cnt_full;
    assign start_drop = (st == RX_IDLE) && frm_start && cnt_full;
    assign byte_drop  = (st == RX_TAKE) && byte_vld && ring_full;
    assign abort      = start_drop || byte_drop;
    assign wr_en      = (st == RX_TAKE) && byte_vld && !ring_full;
    assign commit     = (st == RX_TAKE) && frm_end && !byte_drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= RX_IDLE;
        end else begin
            case (st)
                RX_IDLE: begin
                    if (start_ok)        st <= RX_TAKE;
                    else if (start_drop) st <= RX_DROP;
                end
                RX_TAKE: begin
                    if (byte_drop)       st <= frm_end ? RX_IDLE : RX_DROP;
                    else if (frm_end)    st <= RX_IDLE;
                end
                RX_DROP: begin
                    if (frm_end)         st <= RX_IDLE;
                end
                default:                 st <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            rx_err <= 1'b0;
        else if (abort)     rx_err <= 1'b1;
        else if (cmd.clr)   rx_err <= 1'b0;
    end

    assign irq = rx_err && err_ie && eth_ie;

    rx_admit_rdptr u_rdptr (
        .clk    (clk),
        .rst    (rst),
        .lo_we  (cmd.lo_we),
        .hi_we  (cmd.hi_we),
        .wdata  (reg_wdata),
        .rd_ptr (rd_ptr)
    );

    rx_admit_pktcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (commit),
        .dec_req (cmd.dec),
        .cnt     (pkt_count),
        .full    (cnt_full)
    );

    rx_admit_wrptr #(.ADDR_W(ADDR_W)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .mark      (start_ok),
        .advance   (wr_en),
        .rollback  (byte_drop),
        .rd_ptr    (rd_ptr),
        .wr_ptr    (wr_addr),
        .ring_full (ring_full)
    );

    // R6: any abort raises the error flag
    a_r6_abort_flags: assert property (@(posedge clk) disable iff (rst)
        abort |=> rx_err);
    // R7: the flag holds until a clear write
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_err && !cmd.clr) |=> rx_err);
    // R5: a saturated count is never pushed further by a dropped frame
    a_r5_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (st == RX_DROP && cnt_full && !cmd.dec) |=> cnt_full);
    // R4: nothing is written while a frame is being discarded
    a_r4_drop_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == RX_DROP) |-> !wr_en);
endmodule

// File: tb/sim_rx_admit_ctrl.sv
module sim_rx_admit_ctrl;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          frm_start, byte_vld, frm_end;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          reg_we;
    logic [1:0]    reg_sel;
    logic [7:0]    reg_wdata;
    logic [15:0]   rd_ptr;
    logic [7:0]    pkt_count;
    logic          err_ie, eth_ie;
    logic          rx_err, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    rx_admit_ctrl #(.ADDR_W(AW), .CNT_W(8)) u0 (
        .clk(clk), .rst(rst), .frm_start(frm_start), .byte_vld(byte_vld),
        .frm_end(frm_end), .wr_en(wr_en), .wr_addr(wr_addr), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_ptr(rd_ptr),
        .pkt_count(pkt_count), .err_ie(err_ie), .eth_ie(eth_ie),
        .rx_err(rx_err), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in;
        frm_start = 0; byte_vld = 0; frm_end = 0; reg_we = 0;
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_we = 0;
    endtask

    task automatic f_start;
        frm_start = 1; tick(); frm_start = 0;
    endtask

    task automatic f_end;
        frm_end = 1; tick(); frm_end = 0;
    endtask

    // one byte; returns the wr_en seen in that cycle
    task automatic f_byte(output logic en, output logic [AW-1:0] a);
        byte_vld = 1;
        #1;
        en = wr_en; a = wr_addr;
        tick();
        byte_vld = 0;
    endtask

    task automatic t_reset;
        rst = 1; idle_in(); err_ie = 0; eth_ie = 0; reg_sel = 0; reg_wdata = 0;
        tick(); tick();
        rst = 0;
        chk(pkt_count == 0, "R1 count", pkt_count, 0);
        chk(rx_err == 0,    "R1 flag",  rx_err, 0);
        chk(wr_addr == 0,   "R1 wr_addr", wr_addr, 0);
        chk(rd_ptr == 0,    "R1 rd_ptr", rd_ptr, 0);
        chk(irq == 0,       "R1 irq", irq, 0);
    endtask

    task automatic t_frame;
        logic en; logic [AW-1:0] a; bit ok = 1;
        f_start();
        for (int i = 0; i < 5; i++) begin
            f_byte(en, a);
            if (!(en && a == AW'(i))) ok = 0;
        end
        chk(ok, "R2 bytes stored in order", int'(a), 4);
        f_end();
        chk(pkt_count == 1, "R9 count after frame", pkt_count, 1);
        chk(wr_addr == 5,   "R2 wr_addr after frame", wr_addr, 5);
    endtask

    task automatic t_overflow;
        logic en; logic [AW-1:0] a; int stored = 0; logic en59;
        // rd=0, wr=5: free = (0-5-1) mod 64 = 58
        f_start();
        for (int i = 0; i < 70; i++) begin
            f_byte(en, a);
            if (en) stored++;
            if (i == 58) en59 = en;
        end
        chk(stored == 58, "R3 bytes stored before full", stored, 58);
        chk(en59 == 0,    "R3 no write when full", en59, 0);
        chk(wr_addr == 5, "R4 rollback to frame start", wr_addr, 5);
        chk(rx_err == 1,  "R6 flag on overflow", rx_err, 1);
        f_end();
        chk(pkt_count == 1, "R4 dropped frame not counted", pkt_count, 1);
    endtask

    task automatic t_irq;
        err_ie = 1; eth_ie = 0; #1;
        chk(irq == 0, "R8 irq gated by eth_ie", irq, 0);
        err_ie = 0; eth_ie = 1; #1;
        chk(irq == 0, "R8 irq gated by err_ie", irq, 0);
        err_ie = 1; eth_ie = 1; #1;
        chk(irq == 1, "R8 irq all set", irq, 1);
        tick(); tick();
        chk(rx_err == 1, "R7 flag sticky", rx_err, 1);
        reg_wr(2'b11, 8'h00);
        chk(rx_err == 0, "R7 flag cleared", rx_err, 0);
        chk(irq == 0,    "R8 irq drops with flag", irq, 0);
    endtask

    task automatic t_rdptr;
        reg_wr(2'b00, 8'h05);
        chk(rd_ptr == 16'h0000, "R11 low write held", rd_ptr, 0);
        reg_wr(2'b01, 8'h01);
        chk(rd_ptr == 16'h0105, "R11 pointer committed", rd_ptr, 16'h0105);
        reg_wr(2'b10, 8'h00);
        chk(pkt_count == 0, "R10 decrement", pkt_count, 0);
        reg_wr(2'b10, 8'h00);
        chk(pkt_count == 0, "R10 no underflow", pkt_count, 0);
    endtask

    task automatic t_wrap;
        logic en; logic [AW-1:0] a; int stored = 0; logic [AW-1:0] last = '0;
        // rd low bits = 5, wr = 5: free 63, frame of 63 wraps past 63 to 3
        f_start();
        for (int i = 0; i < 63; i++) begin
            f_byte(en, a);
            if (en) begin stored++; last = a; end
        end
        f_end();
        chk(stored == 63 && last == 3, "R2 wrap across ring end", int'(last), 3);
        chk(wr_addr == 4,   "R3 ring full leaves one gap", wr_addr, 4);
        chk(pkt_count == 1, "R9 wrapped frame counted", pkt_count, 1);
        chk(rx_err == 0,    "R6 no error on exact fit", rx_err, 0);
    endtask

    task automatic t_same_cycle;
        logic en;
        // empty frame ends together with a decrement write
        f_start();
        frm_end = 1; reg_we = 1; reg_sel = 2'b10;
        tick();
        frm_end = 0; reg_we = 0;
        chk(pkt_count == 1, "R10 inc and dec together", pkt_count, 1);
        // ring is full: byte abort coincides with error clear
        f_start();
        byte_vld = 1; reg_we = 1; reg_sel = 2'b11;
        #1 en = wr_en;
        tick();
        byte_vld = 0; reg_we = 0;
        chk(en == 0,     "R3 full ring refuses byte", en, 0);
        chk(rx_err == 1, "R7 set wins over clear", rx_err, 1);
        f_end();
        chk(pkt_count == 1, "R4 aborted frame not counted", pkt_count, 1);
        reg_wr(2'b11, 8'h00);
    endtask

    task automatic t_saturate;
        logic en; logic [AW-1:0] a; bit quiet = 1;
        // free the ring so only the count can block
        reg_wr(2'b00, 8'h03);
        reg_wr(2'b01, 8'h00);
        for (int i = 0; i < 254; i++) begin
            f_start(); f_end();
        end
        chk(pkt_count == 255, "R9 count reaches 255", pkt_count, 255);
        chk(rx_err == 0, "R5 no error before saturation drop", rx_err, 0);
        f_start();
        chk(rx_err == 1, "R5 saturated start flags", rx_err, 1);
        for (int i = 0; i < 3; i++) begin
            f_byte(en, a);
            if (en) quiet = 0;
        end
        chk(quiet, "R5 no bytes stored when saturated", quiet, 1);
        chk(wr_addr == 4, "R5 wr_addr untouched", wr_addr, 4);
        f_end();
        chk(pkt_count == 255, "R5 count stays saturated", pkt_count, 255);
        reg_wr(2'b10, 8'h00);
        chk(pkt_count == 254, "R10 decrement from 255", pkt_count, 254);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_frame();
        t_overflow();
        t_irq();
        t_rdptr();
        t_wrap();
        t_same_cycle();
        t_saturate();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule